// File: doc/BRIEF.md
# Calendar Time-of-Day Counter

This block keeps a wall-clock time and calendar date in eight byte-wide fields: second, minute, hour, weekday, day of month, month, year and century. Every time the one-second strobe arrives, the whole set moves forward by one second. Carries ripple from seconds up through the century within the same clock cycle.

A mode input selects how all fields are encoded: packed BCD (two decimal digits per byte) or plain binary. A second mode input selects how the hour is presented: 24-hour form, or 12-hour form with an afternoon flag. Month lengths come from a fixed table with no leap-year correction.

A hold input suspends advancing, so that software can rewrite the fields while they are stable. A parallel load writes all eight fields at once, and the load takes precedence over the strobe.

Top module: `cal_time_counter`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, the outputs hold the reset date. This is century 0x20, year 0x08, month 0x01, day 0x01, weekday 0x01, and hour, minute and second 0x00.
- R2: Without a strobe, nothing changes. A strobe with `upd_hold` low and `load_en` low increments the second field, and the outputs show the new value one clock after the strobe. In BCD mode (`bcd_mode`=1), a low digit that reaches ten becomes 0 and increments the high digit, so 0x09 becomes 0x10. In binary mode, 9 becomes 0x0A.
- R3: A second that reaches 60 (0x60 in BCD) becomes 0 and increments the minute. A minute that reaches 60 becomes 0 and increments the hour.
- R4: With `mode_24h`=1, an hour increment from 23 (0x23 in BCD) gives 0 and starts a new day.
- R5: With `mode_24h`=0, bit 7 of the hour marks the afternoon, and bits 6:0 count 0 to 11, where 0 stands for twelve o'clock. An hour increment first converts the hour to a 0–23 count, then adds one. A result below 12 is stored as is. A result of 12 to 23 is stored as the result minus 12 with bit 7 set. A result of 24 gives 0x00 and starts a new day. Examples: BCD 0x11 becomes 0x80, BCD 0x91 becomes 0x00, binary 0x8B becomes 0x00, and binary 0x80 becomes 0x81.
- R6: On a new day, the weekday is incremented and then reduced modulo 7, so 6 is followed by 0.
- R7: On a new day, the day of month compares against the length of the current month. Months 1, 3, 5, 7, 8, 10 and 12 have 31 days, months 4, 6, 9 and 11 have 30, month 2 has 28, and any other month value counts as 30 (all written in the active encoding). If the day equals that length, it becomes 1 and the month is incremented. Otherwise the day is incremented.
- R8: A month that reaches 13 becomes 1 and increments the year. A year that overflows becomes 0 and increments the century. In BCD, overflow is a carry out of the high digit (0x99 to 0x00). In binary, overflow means the value reached 100.
- R9: While `upd_hold` is high, strobes are ignored and all fields keep their values.
- R10: When `load_en` is high, every field takes its load port value on the next clock edge, whatever the state of `tick_1hz` and `upd_hold`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-second strobe, one cycle wide |
| upd_hold | input | 1 | Suspends advancing while high |
| bcd_mode | input | 1 | 1 = packed BCD fields, 0 = binary |
| mode_24h | input | 1 | 1 = 24-hour hour field, 0 = 12-hour with PM in bit 7 |
| load_en | input | 1 | Parallel load of all fields |
| ld_sec | input | 8 | Load value, second |
| ld_min | input | 8 | Load value, minute |
| ld_hour | input | 8 | Load value, hour |
| ld_wday | input | 8 | Load value, weekday |
| ld_mday | input | 8 | Load value, day of month |
| ld_month | input | 8 | Load value, month |
| ld_year | input | 8 | Load value, year |
| ld_cent | input | 8 | Load value, century |
| sec_o | output | 8 | Second |
| min_o | output | 8 | Minute |
| hour_o | output | 8 | Hour |
| wday_o | output | 8 | Weekday |
| mday_o | output | 8 | Day of month |
| month_o | output | 8 | Month |
| year_o | output | 8 | Year |
| cent_o | output | 8 | Century |

## Verification
The advance is exercised from loaded start points that stop the carry chain at a different field each time:
- a plain second increment;
- a digit carry inside the second field;
- minute and hour rollovers;
- end-of-day with each kind of month length, including February and an invalid month;
- end of year, both with and without a century carry.

Each start point is run in both BCD and binary encodings. This separates the decimal digit carry from a binary increment and the 0x60/60 wrap thresholds from each other. Twelve-hour cases cover the morning-to-noon step, the step from eleven at night to midnight, and a step after noon, which tells the PM conversion apart from plain counting. Hold and load patterns applied together with a strobe show which of the three inputs takes precedence.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int BYTE_W     = 8;
    localparam int NUM_FIELDS = 8;
    localparam int BUS_W      = BYTE_W * NUM_FIELDS;

    typedef logic [BYTE_W-1:0] byte_t;

    // Field order, most significant first, matches a flat {cent..sec} bus.
    typedef struct packed {
        byte_t cent;
        byte_t year;
        byte_t month;
        byte_t mday;
        byte_t wday;
        byte_t hour;
        byte_t min;
        byte_t sec;
    } cal_time_t;

    // Increment by one in the selected encoding; bit 8 is the carry out.
    function automatic logic [BYTE_W:0] inc_full(input byte_t v, input logic bcd);
        logic [4:0] lo;
        logic [4:0] hi;
        logic       c0;
        logic       c1;
        if (bcd) begin
            lo = {1'b0, v[3:0]} + 5'd1;
            c0 = (lo >= 5'd10);
            if (c0) lo = lo - 5'd10;
            hi = {1'b0, v[7:4]} + {4'd0, c0};
            c1 = (hi >= 5'd10);
            if (c1) hi = hi - 5'd10;
            return {c1, hi[3:0], lo[3:0]};
        end
        return {1'b0, v} + 9'd1;
    endfunction

    function automatic byte_t inc_val(input byte_t v, input logic bcd);
        logic [BYTE_W:0] r;
        r = inc_full(v, bcd);
        return r[BYTE_W-1:0];
    endfunction

    function automatic logic inc_carry(input byte_t v, input logic bcd);
        logic [BYTE_W:0] r;
        r = inc_full(v, bcd);
        return r[BYTE_W];
    endfunction

    // Encode a binary constant in the selected encoding (values below 100).
    function automatic byte_t enc(input byte_t b, input logic bcd);
        byte_t tens;
        byte_t ones;
        if (!bcd) return b;
        tens = b / 8'd10;
        ones = b - tens * 8'd10;
        return {tens[3:0], ones[3:0]};
    endfunction

    function automatic byte_t dec(input byte_t v, input logic bcd);
        if (!bcd) return v;
        return {4'd0, v[7:4]} * 8'd10 + {4'd0, v[3:0]};
    endfunction

    // Fixed month length table, no leap-year rule.
    function automatic byte_t month_len(input byte_t m, input logic bcd);
        byte_t n;
        if (bcd) begin
            case (m)
                8'h01, 8'h03, 8'h05, 8'h07, 8'h08, 8'h10, 8'h12: n = 8'd31;
                8'h02:                                            n = 8'd28;
                default:                                          n = 8'd30;
            endcase
        end else begin
            case (m)
                8'd1, 8'd3, 8'd5, 8'd7, 8'd8, 8'd10, 8'd12: n = 8'd31;
                8'd2:                                        n = 8'd28;
                default:                                     n = 8'd30;
            endcase
        end
        return enc(n, bcd);
    endfunction

endpackage

// File: rtl/cal_clock_stage.sv
module cal_clock_stage
    import cal_pkg::*;
(
    input  byte_t sec_i,
    input  byte_t min_i,
    input  byte_t hour_i,
    input  logic  bcd,
    input  logic  h24,
    output byte_t sec_n,
    output byte_t min_n,
    output byte_t hour_n,
    output logic  day_carry
);
    localparam byte_t SIXTY = 8'd60;
    localparam byte_t HALF  = 8'd12;
    localparam byte_t FULL  = 8'd24;
    localparam byte_t PM_BIT = 8'h80;

    byte_t s_inc;
    byte_t m_inc;
    logic  sec_wrap;
    logic  min_wrap;
    byte_t h_raw;
    byte_t h_bin;
    byte_t h_next;
    logic  is_pm;
    logic  day_wrap;
    byte_t h_enc;

    always_comb begin
        s_inc    = inc_val(sec_i, bcd);
        sec_wrap = (s_inc == enc(SIXTY, bcd));
        sec_n    = sec_wrap ? '0 : s_inc;

        m_inc    = inc_val(min_i, bcd);
        min_wrap = sec_wrap && (m_inc == enc(SIXTY, bcd));
        if (!sec_wrap)     min_n = min_i;
        else if (min_wrap) min_n = '0;
        else               min_n = m_inc;

        // Hour is worked in a binary 0..23 count, then re-encoded.
        is_pm    = !h24 && hour_i[7];
        h_raw    = h24 ? hour_i : (hour_i & 8'h7f);
        h_bin    = dec(h_raw, bcd) + (is_pm ? HALF : 8'd0) + 8'd1;
        day_wrap = (h_bin == FULL);
        h_next   = day_wrap ? 8'd0 : h_bin;
        if (h24 || h_next < HALF) h_enc = enc(h_next, bcd);
        else                      h_enc = enc(h_next - HALF, bcd) | PM_BIT;

        hour_n    = min_wrap ? h_enc : hour_i;
        day_carry = min_wrap && day_wrap;
    end
endmodule

// File: rtl/cal_date_stage.sv
module cal_date_stage
    import cal_pkg::*;
(
    input  byte_t wday_i,
    input  byte_t mday_i,
    input  byte_t month_i,
    input  byte_t year_i,
    input  byte_t cent_i,
    input  logic  bcd,
    input  logic  new_day,
    output byte_t wday_n,
    output byte_t mday_n,
    output byte_t month_n,
    output byte_t year_n,
    output byte_t cent_n
);
    localparam byte_t WEEK      = 8'd7;
    localparam byte_t MONTHS_P1 = 8'd13;
    localparam byte_t CENTURY   = 8'd100;

    logic  last_day;
    byte_t mo_inc;
    logic  mo_wrap;
    byte_t yr_inc;
    logic  yr_wrap;

    always_comb begin
        last_day = (mday_i == month_len(month_i, bcd));
        mo_inc   = inc_val(month_i, bcd);
        mo_wrap  = last_day && (mo_inc == enc(MONTHS_P1, bcd));
        yr_inc   = inc_val(year_i, bcd);
        yr_wrap  = bcd ? inc_carry(year_i, bcd) : (yr_inc == CENTURY);

        wday_n  = wday_i;
        mday_n  = mday_i;
        month_n = month_i;
        year_n  = year_i;
        cent_n  = cent_i;
        if (new_day) begin
            wday_n = inc_val(wday_i, bcd) % WEEK;
            if (!last_day) begin
                mday_n = inc_val(mday_i, bcd);
            end else begin
                mday_n  = 8'd1;
                month_n = mo_wrap ? 8'd1 : mo_inc;
                if (mo_wrap) begin
                    year_n = yr_wrap ? 8'd0 : yr_inc;
                    if (yr_wrap) cent_n = inc_val(cent_i, bcd);
                end
            end
        end
    end
endmodule

// File: rtl/cal_time_counter.sv
module cal_time_counter
    import cal_pkg::*;
#(
    parameter logic [7:0] RST_CENT  = 8'h20,
    parameter logic [7:0] RST_YEAR  = 8'h08,
    parameter logic [7:0] RST_MONTH = 8'h01,
    parameter logic [7:0] RST_MDAY  = 8'h01,
    parameter logic [7:0] RST_WDAY  = 8'h01
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_1hz,
    input  logic       upd_hold,
    input  logic       bcd_mode,
    input  logic       mode_24h,
    input  logic       load_en,
    input  logic [7:0] ld_sec,
    input  logic [7:0] ld_min,
    input  logic [7:0] ld_hour,
    input  logic [7:0] ld_wday,
    input  logic [7:0] ld_mday,
    input  logic [7:0] ld_month,
    input  logic [7:0] ld_year,
    input  logic [7:0] ld_cent,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hour_o,
    output logic [7:0] wday_o,
    output logic [7:0] mday_o,
    output logic [7:0] month_o,
    output logic [7:0] year_o,
    output logic [7:0] cent_o
);
    localparam cal_time_t RST_TIME = '{
        cent: RST_CENT, year: RST_YEAR, month: RST_MONTH, mday: RST_MDAY,
        wday: RST_WDAY, hour: 8'h00, min: 8'h00, sec: 8'h00
    };

    cal_time_t cur_q;
    cal_time_t nxt;
    cal_time_t ld_val;
    logic      new_day;
    logic      advance;

    assign ld_val  = '{cent: ld_cent, year: ld_year, month: ld_month, mday: ld_mday,
                       wday: ld_wday, hour: ld_hour, min: ld_min, sec: ld_sec};
    assign advance = tick_1hz && !upd_hold;

    cal_clock_stage u_clock (
        .sec_i     (cur_q.sec),
        .min_i     (cur_q.min),
        .hour_i    (cur_q.hour),
        .bcd       (bcd_mode),
        .h24       (mode_24h),
        .sec_n     (nxt.sec),
        .min_n     (nxt.min),
        .hour_n    (nxt.hour),
        .day_carry (new_day)
    );

    cal_date_stage u_date (
        .wday_i  (cur_q.wday),
        .mday_i  (cur_q.mday),
        .month_i (cur_q.month),
        .year_i  (cur_q.year),
        .cent_i  (cur_q.cent),
        .bcd     (bcd_mode),
        .new_day (new_day),
        .wday_n  (nxt.wday),
        .mday_n  (nxt.mday),
        .month_n (nxt.month),
        .year_n  (nxt.year),
        .cent_n  (nxt.cent)
    );

    always_ff @(posedge clk) begin
        if (rst)          cur_q <= RST_TIME;
        else if (load_en) cur_q <= ld_val;
        else if (advance) cur_q <= nxt;
    end

    assign sec_o   = cur_q.sec;
    assign min_o   = cur_q.min;
    assign hour_o  = cur_q.hour;
    assign wday_o  = cur_q.wday;
    assign mday_o  = cur_q.mday;
    assign month_o = cur_q.month;
    assign year_o  = cur_q.year;
    assign cent_o  = cur_q.cent;
endmodule

// File: rtl/cal_time_counter_chk.sv
module cal_time_counter_chk (
    input logic       clk,
    input logic       rst,
    input logic       tick_1hz,
    input logic       upd_hold,
    input logic       bcd_mode,
    input logic       mode_24h,
    input logic       load_en,
    input logic [7:0] ld_sec,
    input logic [7:0] ld_min,
    input logic [7:0] ld_hour,
    input logic [7:0] ld_wday,
    input logic [7:0] ld_mday,
    input logic [7:0] ld_month,
    input logic [7:0] ld_year,
    input logic [7:0] ld_cent,
    input logic [7:0] sec_o,
    input logic [7:0] min_o,
    input logic [7:0] hour_o,
    input logic [7:0] wday_o,
    input logic [7:0] mday_o,
    input logic [7:0] month_o,
    input logic [7:0] year_o,
    input logic [7:0] cent_o
);
    logic [63:0] outs;
    logic [63:0] lds;
    logic        step;
    logic        at59;
    logic        eod24;

    assign outs  = {cent_o, year_o, month_o, mday_o, wday_o, hour_o, min_o, sec_o};
    assign lds   = {ld_cent, ld_year, ld_month, ld_mday, ld_wday, ld_hour, ld_min, ld_sec};
    assign step  = tick_1hz && !upd_hold && !load_en;
    assign at59  = (sec_o == (bcd_mode ? 8'h59 : 8'd59));
    assign eod24 = step && mode_24h && at59 && (min_o == (bcd_mode ? 8'h59 : 8'd59))
                   && (hour_o == (bcd_mode ? 8'h23 : 8'd23));

    // R2: no strobe and no load leaves every field unchanged
    assert_idle_stable_R2: assert property (@(posedge clk) disable iff (rst)
        (!tick_1hz && !load_en) |=> $stable(outs));

    // R3: second wraps to zero after 59
    assert_sec_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (step && at59) |=> (sec_o == 8'h00));

    // R4: day rollover in 24-hour mode returns the hour to zero
    assert_hour_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        eod24 |=> (hour_o == 8'h00));

    // R6: a valid weekday stays within 0..6 across a day rollover
    assert_wday_range_R6: assert property (@(posedge clk) disable iff (rst)
        (eod24 && wday_o < 8'd7) |=> (wday_o < 8'd7));

    // R9: hold freezes all fields
    assert_hold_freeze_R9: assert property (@(posedge clk) disable iff (rst)
        (upd_hold && !load_en) |=> $stable(outs));

    // R10: load writes every field
    assert_load_all_R10: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (outs == $past(lds)));
endmodule

bind cal_time_counter cal_time_counter_chk u_chk (.*);

// File: tb/cal_time_counter_tb.sv
module cal_time_counter_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_1hz = 1'b0;
    logic       upd_hold = 1'b0;
    logic       bcd_mode = 1'b1;
    logic       mode_24h = 1'b1;
    logic       load_en = 1'b0;
    logic [63:0] ld_bus = '0;
    logic [7:0] sec_o, min_o, hour_o, wday_o, mday_o, month_o, year_o, cent_o;
    logic [63:0] out_bus;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic [63:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    cal_time_counter u_dut (
        .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .upd_hold(upd_hold),
        .bcd_mode(bcd_mode), .mode_24h(mode_24h), .load_en(load_en),
        .ld_sec(ld_bus[7:0]), .ld_min(ld_bus[15:8]), .ld_hour(ld_bus[23:16]),
        .ld_wday(ld_bus[31:24]), .ld_mday(ld_bus[39:32]), .ld_month(ld_bus[47:40]),
        .ld_year(ld_bus[55:48]), .ld_cent(ld_bus[63:56]),
        .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .wday_o(wday_o),
        .mday_o(mday_o), .month_o(month_o), .year_o(year_o), .cent_o(cent_o)
    );

    assign out_bus = {cent_o, year_o, month_o, mday_o, wday_o, hour_o, min_o, sec_o};

    function automatic logic [63:0] tv(input logic [7:0] c, y, mo, md, w, h, mi, s);
        return {c, y, mo, md, w, h, mi, s};
    endfunction

    // Monitor: compares one expected item per cycle, half a period after the edge.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [63:0] e;
            string       t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_cmp++;
            if (out_bus !== e) begin
                n_bad++;
                $display("FAIL %s: got %h expected %h", t, out_bus, e);
            end
        end
    end

    // Driver: applies one cycle of stimulus and queues the value expected after it.
    task automatic step(input logic t, input logic h, input logic l,
                        input logic [63:0] ldv, input logic [63:0] ex, input string tag);
        @(negedge clk);
        tick_1hz = t;
        upd_hold = h;
        load_en  = l;
        ld_bus   = ldv;
        @(posedge clk);
        #1;
        exp_q.push_back(ex);
        tag_q.push_back(tag);
        tick_1hz = 1'b0;
        upd_hold = 1'b0;
        load_en  = 1'b0;
    endtask

    task automatic load_then_tick(input logic [63:0] start, input logic [63:0] ex, input string tag);
        step(1'b0, 1'b0, 1'b1, start, start, tag);
        step(1'b1, 1'b0, 1'b0, '0, ex, tag);
    endtask

    initial begin
        logic [63:0] rst_t;
        rst_t = tv(8'h20, 8'h08, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00);
        repeat (3) @(posedge clk);
        exp_q.push_back(rst_t); tag_q.push_back("R1 reset value during reset");
        @(negedge clk);
        rst = 1'b0;

        step(1'b0, 1'b0, 1'b0, '0, rst_t, "R1 first cycle after reset");
        step(1'b1, 1'b0, 1'b0, '0, tv(8'h20, 8'h08, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h01), "R2 single second");
        step(1'b0, 1'b0, 1'b0, '0, tv(8'h20, 8'h08, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h01), "R2 no strobe");
        load_then_tick(tv(8'h20, 8'h08, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h09),
                       tv(8'h20, 8'h08, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h10), "R2 BCD digit carry");
        bcd_mode = 1'b0;
        load_then_tick(tv(8'h20, 8'h08, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h09),
                       tv(8'h20, 8'h08, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h0A), "R2 binary increment");

        bcd_mode = 1'b1;
        load_then_tick(tv(8'h20, 8'h08, 8'h01, 8'h01, 8'h01, 8'h12, 8'h59, 8'h59),
                       tv(8'h20, 8'h08, 8'h01, 8'h01, 8'h01, 8'h13, 8'h00, 8'h00), "R3 BCD minute/hour carry");
        bcd_mode = 1'b0;
        load_then_tick(tv(8'h20, 8'h08, 8'h01, 8'h01, 8'h01, 8'h05, 8'h0A, 8'h3B),
                       tv(8'h20, 8'h08, 8'h01, 8'h01, 8'h01, 8'h05, 8'h0B, 8'h00), "R3 binary second wrap");
        load_then_tick(tv(8'h20, 8'h08, 8'h01, 8'h01, 8'h01, 8'h05, 8'h3B, 8'h3B),
                       tv(8'h20, 8'h08, 8'h01, 8'h01, 8'h01, 8'h06, 8'h00, 8'h00), "R3 binary minute wrap");

        bcd_mode = 1'b1;
        load_then_tick(tv(8'h20, 8'h08, 8'h04, 8'h15, 8'h06, 8'h23, 8'h59, 8'h59),
                       tv(8'h20, 8'h08, 8'h04, 8'h16, 8'h00, 8'h00, 8'h00, 8'h00), "R4 R6 day rollover, weekday 6 to 0");

        mode_24h = 1'b0;
        load_then_tick(tv(8'h20, 8'h08, 8'h04, 8'h15, 8'h02, 8'h11, 8'h59, 8'h59),
                       tv(8'h20, 8'h08, 8'h04, 8'h15, 8'h02, 8'h80, 8'h00, 8'h00), "R5 BCD 11 AM to noon");
        load_then_tick(tv(8'h20, 8'h08, 8'h04, 8'h15, 8'h02, 8'h91, 8'h59, 8'h59),
                       tv(8'h20, 8'h08, 8'h04, 8'h16, 8'h03, 8'h00, 8'h00, 8'h00), "R5 BCD 11 PM to midnight");
        bcd_mode = 1'b0;
        load_then_tick(tv(8'h14, 8'h08, 8'h04, 8'h0F, 8'h02, 8'h8B, 8'h3B, 8'h3B),
                       tv(8'h14, 8'h08, 8'h04, 8'h10, 8'h03, 8'h00, 8'h00, 8'h00), "R5 binary 11 PM to midnight");
        load_then_tick(tv(8'h14, 8'h08, 8'h04, 8'h0F, 8'h02, 8'h80, 8'h3B, 8'h3B),
                       tv(8'h14, 8'h08, 8'h04, 8'h0F, 8'h02, 8'h81, 8'h00, 8'h00), "R5 binary after noon");

        bcd_mode = 1'b1;
        mode_24h = 1'b1;
        load_then_tick(tv(8'h20, 8'h08, 8'h04, 8'h30, 8'h03, 8'h23, 8'h59, 8'h59),
                       tv(8'h20, 8'h08, 8'h05, 8'h01, 8'h04, 8'h00, 8'h00, 8'h00), "R7 30-day month end");
        load_then_tick(tv(8'h20, 8'h08, 8'h01, 8'h30, 8'h03, 8'h23, 8'h59, 8'h59),
                       tv(8'h20, 8'h08, 8'h01, 8'h31, 8'h04, 8'h00, 8'h00, 8'h00), "R7 31-day month not ended");
        load_then_tick(tv(8'h20, 8'h08, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59),
                       tv(8'h20, 8'h08, 8'h03, 8'h01, 8'h04, 8'h00, 8'h00, 8'h00), "R7 February end");
        load_then_tick(tv(8'h20, 8'h08, 8'h15, 8'h30, 8'h03, 8'h23, 8'h59, 8'h59),
                       tv(8'h20, 8'h08, 8'h16, 8'h01, 8'h04, 8'h00, 8'h00, 8'h00), "R7 invalid month as 30");
        load_then_tick(tv(8'h20, 8'h45, 8'h12, 8'h31, 8'h03, 8'h23, 8'h59, 8'h59),
                       tv(8'h20, 8'h46, 8'h01, 8'h01, 8'h04, 8'h00, 8'h00, 8'h00), "R8 BCD year end");
        load_then_tick(tv(8'h20, 8'h99, 8'h12, 8'h31, 8'h03, 8'h23, 8'h59, 8'h59),
                       tv(8'h21, 8'h00, 8'h01, 8'h01, 8'h04, 8'h00, 8'h00, 8'h00), "R8 BCD century carry");
        bcd_mode = 1'b0;
        load_then_tick(tv(8'h14, 8'h63, 8'h0C, 8'h1F, 8'h03, 8'h17, 8'h3B, 8'h3B),
                       tv(8'h15, 8'h00, 8'h01, 8'h01, 8'h04, 8'h00, 8'h00, 8'h00), "R8 binary century carry");

        bcd_mode = 1'b1;
        step(1'b0, 1'b0, 1'b1, tv(8'h20, 8'h08, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h05),
             tv(8'h20, 8'h08, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h05), "R10 plain load");
        step(1'b1, 1'b1, 1'b0, '0, tv(8'h20, 8'h08, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h05), "R9 strobe under hold");
        step(1'b0, 1'b1, 1'b0, '0, tv(8'h20, 8'h08, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h05), "R9 hold alone");
        step(1'b1, 1'b0, 1'b0, '0, tv(8'h20, 8'h08, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h06), "R9 resumes after hold");
        step(1'b1, 1'b0, 1'b1, tv(8'h20, 8'h10, 8'h06, 8'h12, 8'h03, 8'h07, 8'h30, 8'h45),
             tv(8'h20, 8'h10, 8'h06, 8'h12, 8'h03, 8'h07, 8'h30, 8'h45), "R10 load beats strobe");
        step(1'b0, 1'b1, 1'b1, tv(8'h19, 8'h99, 8'h12, 8'h31, 8'h05, 8'h22, 8'h15, 8'h30),
             tv(8'h19, 8'h99, 8'h12, 8'h31, 8'h05, 8'h22, 8'h15, 8'h30), "R10 load under hold");

        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule